// File: doc/BRIEF.md
# Bending-Track Pattern Detector

This block searches one zone of a four-station hit bitmap for track-like coincidences. Each station supplies a row of strip hits. Neighbouring strips are first merged in pairs into double strips. Every double-strip position in the key station is then tried as the anchor of a family of angular patterns. The narrowest pattern describes a nearly straight, high-momentum track. Each wider pattern opens the window in the non-key stations further, so that more strongly bent tracks are still accepted, but with less precision.

At every key position the block keeps the pattern that gives the highest quality code. The code favours a hit in the first station above everything else, then the number of stations hit, then how straight the pattern is. A selector takes the three best key positions in the zone. It reports each one as a registered winner slot with a valid flag, a position, a pattern ID and a quality. The block is used as the azimuthal front stage of a track finder. Its winners feed later stages that merge coordinates and assign parameters.

Top module: `bend_pattern_det`

## Requirements
- R1: Strips 2d and 2d+1 of a station form double strip d; a hit on either strip counts as a hit on that double strip.
- R2: Pattern p (0 to NP-1) sees a station s hit at key d when that station has a double-strip hit within ±STEP[s]·(p+1) of d. STEP[s] sits in bits 4s+3:4s, and the defaults are 2, 0, 1, 2 for stations 0 to 3. The key station (station 1) only looks at d itself. Positions outside 0..ND-1 never count, and there is no wrap-around.
- R3: A pattern is a match only when at least two stations are hit. A key position with no matching pattern has quality 0 and is never reported.
- R4: The quality code is 5 bits. Bit 4 is the station-0 hit. Bits 3:2 hold the number of hit stations minus one. Bits 1:0 hold the straightness NP-1-p. Each key keeps the pattern with the largest code, and the pattern ID reported is p.
- R5: Winner slot 0 holds the highest-quality key, slot 1 the next and slot 2 the third. Positions are distinct, and when qualities are equal the lower position wins.
- R6: When fewer than three keys match, the unused slots have their valid flag cleared. Their position, pattern ID and quality read zero.
- R7: Winners are registered. Hits present before a rising clock edge show up right after that edge, and not earlier. An active-low reset clears every slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hits_i | input | NST×NS | Per-station strip hit bitmap, station s in row s |
| win_vld_o | output | NWIN | Winner slot valid flags |
| win_pos_o | output | NWIN×PW | Winner key position in double strips |
| win_pid_o | output | NWIN×2 | Winning pattern ID (0 is the straightest) |
| win_qual_o | output | NWIN×5 | Winner quality code |

## Verification
The checker takes for granted that the hit bitmap holds known values, that it changes only away from the rising edge, and that reset is asserted at start-up. Under those conditions the slot ordering, the empty-slot zeroing and the link between pattern ID and straightness hold for any bitmap. The bench drives every bitmap on the falling edge, applies reset first and only ever sets or clears whole bitmaps. This keeps each applied pattern stable across the edge that captures it.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
   localparam int PID_W  = 2;
   localparam int CNT_W  = 2;
   localparam int QUAL_W = 1 + CNT_W + PID_W;
   localparam int STEP_W = 4;

   typedef logic [QUAL_W-1:0] qual_t;
   typedef logic [PID_W-1:0]  pid_t;

   function automatic int max_step(input logic [31:0] steps, input int nst);
      int m;
      m = 0;
      for (int s = 0; s < nst; s++) begin
         if (int'(steps[STEP_W*s +: STEP_W]) > m) m = int'(steps[STEP_W*s +: STEP_W]);
      end
      return m;
   endfunction
endpackage

// File: rtl/bpd_pair_or.sv
module bpd_pair_or #(
   parameter int NST = 4,
   parameter int NS  = 64,
   localparam int ND = NS / 2
) (
   input  logic [NST-1:0][NS-1:0] hits_i,
   output logic [NST-1:0][ND-1:0] dhit_o
);
   for (genvar s = 0; s < NST; s++) begin : g_st
      for (genvar d = 0; d < ND; d++) begin : g_ds
         assign dhit_o[s][d] = hits_i[s][2*d] | hits_i[s][2*d+1];
      end
   end
endmodule

// File: rtl/bpd_key_match.sv
module bpd_key_match
   import bpd_pkg::*;
#(
   parameter int          NST    = 4,
   parameter int          ND     = 32,
   parameter int          NP     = 4,
   parameter int          KEY_ST = 1,
   parameter logic [31:0] STEP   = 32'h0000_2102,
   parameter int          KEY    = 0,
   localparam int IW    = (ND > 1) ? $clog2(ND) : 1,
   localparam int MAXHW = max_step(STEP, NST) * NP
) (
   input  logic [NST-1:0][ND-1:0] dhit_i,
   output qual_t                  qual_o,
   output pid_t                   pid_o
);
   always_comb begin
      int    nh;
      int    hw;
      int    idx;
      logic  hit;
      logic  st0;
      qual_t cand;
      qual_o = '0;
      pid_o  = '0;
      for (int p = 0; p < NP; p++) begin
         nh  = 0;
         st0 = 1'b0;
         for (int s = 0; s < NST; s++) begin
            hw  = (s == KEY_ST) ? 0 : int'(STEP[STEP_W*s +: STEP_W]) * (p + 1);
            hit = 1'b0;
            for (int j = -MAXHW; j <= MAXHW; j++) begin
               idx = KEY + j;
               if (j >= -hw && j <= hw && idx >= 0 && idx < ND)
                  hit = hit | dhit_i[s][idx[IW-1:0]];
            end
            if (hit) nh = nh + 1;
            if (s == 0) st0 = hit;
         end
         cand = {st0, CNT_W'(nh - 1), PID_W'(NP - 1 - p)};
         if (nh >= 2 && cand > qual_o) begin
            qual_o = cand;
            pid_o  = PID_W'(p);
         end
      end
   end
endmodule

// File: rtl/bpd_best_sel.sv
module bpd_best_sel
   import bpd_pkg::*;
#(
   parameter int  ND   = 32,
   parameter int  NWIN = 3,
   localparam int PW   = (ND > 1) ? $clog2(ND) : 1
) (
   input  qual_t [ND-1:0]             qual_i,
   input  pid_t  [ND-1:0]             pid_i,
   output logic  [NWIN-1:0]           vld_o,
   output logic  [NWIN-1:0][PW-1:0]   pos_o,
   output pid_t  [NWIN-1:0]           pid_o,
   output qual_t [NWIN-1:0]           qual_o
);
   always_comb begin
      logic [ND-1:0] taken;
      qual_t         bq;
      logic [PW-1:0] bi;
      taken = '0;
      for (int r = 0; r < NWIN; r++) begin
         bq = '0;
         bi = '0;
         for (int i = 0; i < ND; i++) begin
            if (!taken[i] && qual_i[i] > bq) begin
               bq = qual_i[i];
               bi = PW'(i);
            end
         end
         vld_o[r]  = (bq != '0);
         pos_o[r]  = vld_o[r] ? bi : '0;
         pid_o[r]  = vld_o[r] ? pid_i[bi] : '0;
         qual_o[r] = bq;
         if (vld_o[r]) taken[bi] = 1'b1;
      end
   end
endmodule

// File: rtl/bend_pattern_det.sv
module bend_pattern_det
   import bpd_pkg::*;
#(
   parameter int          NST    = 4,
   parameter int          NS     = 64,
   parameter int          NP     = 4,
   parameter int          KEY_ST = 1,
   parameter logic [31:0] STEP   = 32'h0000_2102,
   parameter int          NWIN   = 3,
   localparam int ND = NS / 2,
   localparam int PW = (ND > 1) ? $clog2(ND) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NST-1:0][NS-1:0]      hits_i,
   output logic [NWIN-1:0]             win_vld_o,
   output logic [NWIN-1:0][PW-1:0]     win_pos_o,
   output logic [NWIN-1:0][PID_W-1:0]  win_pid_o,
   output logic [NWIN-1:0][QUAL_W-1:0] win_qual_o
);
   if (NST < 2 || NST > 4) begin : g_bad_nst
      $error("station count must be 2..4");
   end
   if (NS < 4 || (NS % 2) != 0) begin : g_bad_ns
      $error("strip count must be even and at least 4");
   end
   if (NP < 2 || NP > 4) begin : g_bad_np
      $error("pattern count must be 2..4");
   end
   if (KEY_ST < 0 || KEY_ST >= NST) begin : g_bad_key
      $error("key station out of range");
   end
   if (NWIN < 1 || NWIN > ND) begin : g_bad_nwin
      $error("winner count out of range");
   end

   logic  [NST-1:0][ND-1:0] dhit;
   qual_t [ND-1:0]          kq;
   pid_t  [ND-1:0]          kp;
   logic  [NWIN-1:0]           s_vld;
   logic  [NWIN-1:0][PW-1:0]   s_pos;
   pid_t  [NWIN-1:0]           s_pid;
   qual_t [NWIN-1:0]           s_qual;

   bpd_pair_or #(.NST(NST), .NS(NS)) i_pair (
      .hits_i (hits_i),
      .dhit_o (dhit)
   );

   for (genvar k = 0; k < ND; k++) begin : g_key
      bpd_key_match #(
         .NST(NST), .ND(ND), .NP(NP), .KEY_ST(KEY_ST), .STEP(STEP), .KEY(k)
      ) i_match (
         .dhit_i (dhit),
         .qual_o (kq[k]),
         .pid_o  (kp[k])
      );
   end

   bpd_best_sel #(.ND(ND), .NWIN(NWIN)) i_sel (
      .qual_i (kq),
      .pid_i  (kp),
      .vld_o  (s_vld),
      .pos_o  (s_pos),
      .pid_o  (s_pid),
      .qual_o (s_qual)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_vld_o  <= '0;
         win_pos_o  <= '0;
         win_pid_o  <= '0;
         win_qual_o <= '0;
      end else begin
         win_vld_o  <= s_vld;
         win_pos_o  <= s_pos;
         win_pid_o  <= s_pid;
         win_qual_o <= s_qual;
      end
   end
endmodule

// File: rtl/bpd_chk.sv
module bpd_chk
   import bpd_pkg::*;
#(
   parameter int NST  = 4,
   parameter int NS   = 64,
   parameter int NP   = 4,
   parameter int NWIN = 3,
   parameter int PW   = 5
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NST-1:0][NS-1:0]      hits_i,
   input logic [NWIN-1:0]             win_vld_o,
   input logic [NWIN-1:0][PW-1:0]     win_pos_o,
   input logic [NWIN-1:0][PID_W-1:0]  win_pid_o,
   input logic [NWIN-1:0][QUAL_W-1:0] win_qual_o
);
   // R7: an all-zero bitmap yields no winner one edge later
   a_r7_quiet_in_quiet_out: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hits_i == '0) |-> win_vld_o == '0);

   for (genvar r = 0; r < NWIN; r++) begin : g_slot
      // R3: a reported winner always has two or more stations
      a_r3_two_stations: assert property (@(posedge clk) disable iff (!rst_n)
         win_vld_o[r] |-> win_qual_o[r][PID_W +: CNT_W] != '0);
      // R4: straightness field agrees with pattern ID
      a_r4_pid_straight: assert property (@(posedge clk) disable iff (!rst_n)
         win_vld_o[r] |-> (int'(win_pid_o[r]) < NP &&
                           int'(win_qual_o[r][PID_W-1:0]) == NP - 1 - int'(win_pid_o[r])));
      // R6: empty slots read zero
      a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
         !win_vld_o[r] |-> (win_qual_o[r] == '0 && win_pos_o[r] == '0 && win_pid_o[r] == '0));
      if (r > 0) begin : g_pair
         // R6: slots fill from slot 0 upward
         a_r6_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
            win_vld_o[r] |-> win_vld_o[r-1]);
         // R5: non-increasing quality across slots
         a_r5_ordered: assert property (@(posedge clk) disable iff (!rst_n)
            win_vld_o[r] |-> win_qual_o[r-1] >= win_qual_o[r]);
         // R5: neighbouring slots never share a position
         a_r5_distinct: assert property (@(posedge clk) disable iff (!rst_n)
            win_vld_o[r] |-> win_pos_o[r] != win_pos_o[r-1]);
      end
   end
endmodule

bind bend_pattern_det bpd_chk #(
   .NST(NST), .NS(NS), .NP(NP), .NWIN(NWIN), .PW(PW)
) i_bpd_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hits_i     (hits_i),
   .win_vld_o  (win_vld_o),
   .win_pos_o  (win_pos_o),
   .win_pid_o  (win_pid_o),
   .win_qual_o (win_qual_o)
);

// File: tb/test_bend_pattern_det.sv
module test_bend_pattern_det;
   localparam int NST = 4;
   localparam int NS  = 64;
   localparam int PW  = 5;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic [NST-1:0][NS-1:0] hits = '0;
   logic [2:0]             vld;
   logic [2:0][PW-1:0]     pos;
   logic [2:0][1:0]        pid;
   logic [2:0][4:0]        qual;
   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   bend_pattern_det i_bend_pattern_det (
      .clk        (clk),
      .rst_n      (rst_n),
      .hits_i     (hits),
      .win_vld_o  (vld),
      .win_pos_o  (pos),
      .win_pid_o  (pid),
      .win_qual_o (qual)
   );

   task automatic chk(input string req, input int r, input bit ev,
                      input int epos, input int epid, input int eq);
      n_chk++;
      if (vld[r] !== ev || int'(pos[r]) != epos || int'(pid[r]) != epid || int'(qual[r]) != eq) begin
         n_bad++;
         $display("FAIL %s slot%0d: actual vld=%0b pos=%0d pid=%0d q=%0d expected vld=%0b pos=%0d pid=%0d q=%0d",
                  req, r, vld[r], pos[r], pid[r], qual[r], ev, epos, epid, eq);
      end
   endtask

   task automatic chk_empty(input string req, input int r);
      chk(req, r, 1'b0, 0, 0, 0);
   endtask

   // drive on falling edge, sample 1 ns after the capturing rising edge
   task automatic apply(input logic [NST-1:0][NS-1:0] h);
      @(negedge clk);
      hits = h;
      @(posedge clk);
      #1;
   endtask

   function automatic logic [NST-1:0][NS-1:0] put(input logic [NST-1:0][NS-1:0] h,
                                                   input int s, input int strip);
      logic [NST-1:0][NS-1:0] t;
      t = h;
      t[s][strip] = 1'b1;
      return t;
   endfunction

   task automatic t_reset();
      hits = '0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      for (int r = 0; r < 3; r++) chk_empty("R7 reset", r);
      @(negedge clk);
      rst_n = 1'b1;
      apply('0);
      for (int r = 0; r < 3; r++) chk_empty("R3 empty bitmap", r);
   endtask

   task automatic t_single_station();
      apply(put('0, 1, 20));
      for (int r = 0; r < 3; r++) chk_empty("R3 one station", r);
   endtask

   task automatic t_straight();
      logic [NST-1:0][NS-1:0] h;
      h = put('0, 0, 21);
      h = put(h, 1, 20);
      h = put(h, 2, 20);
      h = put(h, 3, 21);
      apply(h);
      chk("R1 R4 straight all-station key", 0, 1'b1, 10, 0, 31);
      chk("R5 tie lower position", 1, 1'b1, 9, 0, 27);
      chk("R5 tie higher position", 2, 1'b1, 11, 0, 27);
   endtask

   task automatic t_st0_priority();
      logic [NST-1:0][NS-1:0] h;
      h = put('0, 1, 10);
      h = put(h, 2, 10);
      h = put(h, 3, 11);
      h = put(h, 0, 50);
      h = put(h, 1, 51);
      apply(h);
      chk("R4 station0 priority", 0, 1'b1, 25, 0, 23);
      chk("R4 three stations no st0", 1, 1'b1, 5, 0, 11);
      chk("R5 R2 neighbour tie", 2, 1'b1, 4, 0, 7);
   endtask

   task automatic t_bent();
      logic [NST-1:0][NS-1:0] h;
      h = put('0, 0, 34);
      h = put(h, 1, 20);
      @(negedge clk);
      hits = h;
      #1;
      chk("R7 no early change", 0, 1'b1, 25, 0, 23);
      @(posedge clk);
      #1;
      chk("R2 R4 widest pattern", 0, 1'b1, 10, 3, 20);
      chk_empty("R6 slot1 cleared", 1);
      chk_empty("R6 slot2 cleared", 2);
   endtask

   task automatic t_too_bent();
      logic [NST-1:0][NS-1:0] h;
      h = put('0, 0, 38);
      h = put(h, 1, 20);
      apply(h);
      chk_empty("R2 outside widest window", 0);
   endtask

   task automatic t_edge();
      logic [NST-1:0][NS-1:0] h;
      h = put('0, 1, 62);
      h = put(h, 2, 63);
      h = put(h, 0, 1);
      apply(h);
      chk("R2 no wrap at edge", 0, 1'b1, 31, 0, 7);
      chk_empty("R6 edge slot1", 1);
   endtask

   task automatic t_four_tracks();
      logic [NST-1:0][NS-1:0] h;
      h = '0;
      h = put(h, 0, 6);  h = put(h, 1, 7);
      h = put(h, 0, 26); h = put(h, 1, 26);
      h = put(h, 0, 47); h = put(h, 1, 46);
      h = put(h, 0, 60); h = put(h, 1, 61);
      apply(h);
      chk("R5 first of four", 0, 1'b1, 3, 0, 23);
      chk("R5 second of four", 1, 1'b1, 13, 0, 23);
      chk("R5 third of four", 2, 1'b1, 23, 0, 23);
   endtask

   task automatic t_reset_mid();
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      for (int r = 0; r < 3; r++) chk_empty("R7 async reset", r);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(8 * 100000);
      n_bad++;
      $display("FAIL R7 watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_single_station();
      t_straight();
      t_st0_priority();
      t_bent();
      t_too_bent();
      t_edge();
      t_four_tracks();
      t_reset_mid();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule